// File: doc/BRIEF.md
# SHA-512 Message Schedule Sigma0 Pre-Add Unit

This unit performs the first half of the SHA-512 message expansion for four schedule words in parallel. A 256-bit vector carries four consecutive 64-bit words. A 128-bit side operand supplies, in its low 64 bits, the word that follows them in the schedule. For each lane the unit adds the lane's own word to the small sigma0 function of the next word up. The top lane takes its neighbour from the side operand. Lanes 0 to 2 take it from the lane above them in the same vector.

The result is captured in a single output register with a valid flag. One cycle after an accepted input, the output presents the four sums. There is no back-pressure, so a new operand pair can enter on every clock. The second expansion step, the compression rounds, padding and block loading belong to neighbouring logic.

Top module: `msg_sched_s0`

## Requirements
- R1: For lanes k = 0, 1 and 2, the 64-bit output lane k (bits 64k+63 down to 64k of `out_words`) equals input lane k of `in_words` plus sigma0 of input lane k+1. Here sigma0(x) = rotr(x,1) XOR rotr(x,8) XOR (x >> 7), where rotr is a circular right rotation and >> is a logical shift filling with zeros.
- R2: Output lane 3 (bits 255:192) equals input lane 3 of `in_words` plus sigma0 of `in_next[63:0]`.
- R3: Bits 127:64 of `in_next` have no effect on `out_words`.
- R4: Each lane sum wraps modulo 2^64, and no carry crosses into the next lane. With every input bit set to one, every output lane reads 0x01FF_FFFF_FFFF_FFFE.
- R5: `out_valid` is high in exactly the cycles that follow a cycle with `in_valid` high. Inputs presented on consecutive cycles each produce their own result on consecutive cycles.
- R6: A synchronous active-high `rst` drives `out_valid` low on the next edge. This holds even when `in_valid` is high in the same cycle.
- R7: While `in_valid` is low, `out_words` keeps the last computed result.
- R8: All-zero inputs give an all-zero result in every lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid flag |
| in_valid | input | 1 | Operands are present this cycle |
| in_words | input | 256 | Four 64-bit schedule words, lane 0 in the low bits |
| in_next | input | 128 | Low 64 bits: the word after lane 3; high 64 bits unused |
| out_valid | output | 1 | `out_words` holds a fresh result |
| out_words | output | 256 | Four 64-bit lane sums, lane 0 in the low bits |

## Verification
Two functions can fall in the same cycle: reset of the valid flag and acceptance of a new operand pair. The bench provokes this by raising `rst` and `in_valid` together. It judges the outcome by requiring `out_valid` to be low after that edge, with reset taking priority. A second overlap arises when a result is presented while the next operand is captured. Streaming vectors back to back exercises it, and every lane must match the model on every cycle, without one result leaking into the next.

// File: rtl/msg_sched_pkg.sv
package msg_sched_pkg;
  parameter int unsigned SCH_WORD_W     = 64;
  parameter int unsigned SCH_LANES      = 4;
  parameter int unsigned SCH_NEXT_LANES = 2;
  parameter int unsigned SCH_ROT_A      = 1;
  parameter int unsigned SCH_ROT_B      = 8;
  parameter int unsigned SCH_SHR_C      = 7;
endpackage

// File: rtl/msg_s0_lane.sv
module msg_s0_lane #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned ROT_A  = 1,
  parameter int unsigned ROT_B  = 8,
  parameter int unsigned SHR_C  = 7
) (
  input  logic [WORD_W-1:0] cur_word,
  input  logic [WORD_W-1:0] nxt_word,
  output logic [WORD_W-1:0] lane_sum
);
  localparam int unsigned RA = ROT_A % WORD_W;
  localparam int unsigned RB = ROT_B % WORD_W;

  logic [WORD_W-1:0] rot_a;
  logic [WORD_W-1:0] rot_b;
  logic [WORD_W-1:0] shr_c;
  logic [WORD_W-1:0] mix;

  generate
    if (RA == 0) begin : g_ra_zero
      assign rot_a = nxt_word;
    end else begin : g_ra_rot
      assign rot_a = {nxt_word[RA-1:0], nxt_word[WORD_W-1:RA]};
    end
    if (RB == 0) begin : g_rb_zero
      assign rot_b = nxt_word;
    end else begin : g_rb_rot
      assign rot_b = {nxt_word[RB-1:0], nxt_word[WORD_W-1:RB]};
    end
  endgenerate

  assign shr_c    = nxt_word >> SHR_C;
  assign mix      = rot_a ^ rot_b ^ shr_c;
  assign lane_sum = cur_word + mix;
endmodule

// File: rtl/msg_s0_reg.sv
module msg_s0_reg #(
  parameter int unsigned DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d_in,
  output logic              v_out,
  output logic [DATA_W-1:0] d_out
);
  always_ff @(posedge clk) begin
    if (rst) v_out <= 1'b0;
    else     v_out <= load;
  end

  always_ff @(posedge clk) begin
    if (load) d_out <= d_in;
  end
endmodule

// File: rtl/msg_sched_s0.sv
module msg_sched_s0 import msg_sched_pkg::*; #(
  parameter int unsigned WORD_W     = SCH_WORD_W,
  parameter int unsigned LANES      = SCH_LANES,
  parameter int unsigned NEXT_LANES = SCH_NEXT_LANES,
  parameter int unsigned ROT_A      = SCH_ROT_A,
  parameter int unsigned ROT_B      = SCH_ROT_B,
  parameter int unsigned SHR_C      = SCH_SHR_C
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic [WORD_W*LANES-1:0]      in_words,
  input  logic [WORD_W*NEXT_LANES-1:0] in_next,
  output logic                         out_valid,
  output logic [WORD_W*LANES-1:0]      out_words
);
  localparam int unsigned VEC_W  = WORD_W * LANES;
  localparam int unsigned NEXT_W = WORD_W * NEXT_LANES;

  logic [WORD_W-1:0] word_ext [LANES+1];
  logic [VEC_W-1:0]  lane_sum;
  logic              unused_next_hi;

  assign unused_next_hi = ^in_next[NEXT_W-1:WORD_W];

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_split
      assign word_ext[k] = in_words[k*WORD_W +: WORD_W];
    end
  endgenerate
  assign word_ext[LANES] = in_next[WORD_W-1:0];

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      msg_s0_lane #(
        .WORD_W(WORD_W), .ROT_A(ROT_A), .ROT_B(ROT_B), .SHR_C(SHR_C)
      ) u_lane (
        .cur_word(word_ext[k]),
        .nxt_word(word_ext[k+1]),
        .lane_sum(lane_sum[k*WORD_W +: WORD_W])
      );
    end
  endgenerate

  msg_s0_reg #(.DATA_W(VEC_W)) u_out (
    .clk  (clk),
    .rst  (rst),
    .load (in_valid),
    .d_in (lane_sum),
    .v_out(out_valid),
    .d_out(out_words)
  );
endmodule

// File: rtl/msg_sched_s0_chk.sv
module msg_sched_s0_chk #(
  parameter int unsigned WORD_W = 64,
  parameter int unsigned LANES  = 4,
  parameter int unsigned ROT_A  = 1,
  parameter int unsigned ROT_B  = 8,
  parameter int unsigned SHR_C  = 7
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    in_valid,
  input logic [WORD_W*LANES-1:0] in_words,
  input logic [WORD_W-1:0]       next_lo,
  input logic                    out_valid,
  input logic [WORD_W*LANES-1:0] out_words
);
  localparam int unsigned VEC_W = WORD_W * LANES;

  function automatic logic [WORD_W-1:0] ref_s0(input logic [WORD_W-1:0] x);
    logic [2*WORD_W-1:0] dbl;
    logic [WORD_W-1:0]   r1;
    logic [WORD_W-1:0]   r2;
    dbl = {x, x};
    r1  = dbl[ROT_A % WORD_W +: WORD_W];
    r2  = dbl[ROT_B % WORD_W +: WORD_W];
    return r1 ^ r2 ^ (x >> SHR_C);
  endfunction

  logic rst_seen_q;
  always_ff @(posedge clk) rst_seen_q <= rst;

  // R6
  always_ff @(posedge clk) begin
    if (rst_seen_q === 1'b1) begin
      reset_clear_chk: assert (out_valid == 1'b0);
    end
  end

  // R5
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  // R5
  no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  // R7
  hold_data_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && out_valid) |=> $stable(out_words));

  // R1
  low_lane_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_words[WORD_W-1:0] ==
      $past(in_words[WORD_W-1:0]) + ref_s0($past(in_words[2*WORD_W-1:WORD_W])));

  // R2
  top_lane_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_words[VEC_W-1 -: WORD_W] ==
      $past(in_words[VEC_W-1 -: WORD_W]) + ref_s0($past(next_lo)));
endmodule

bind msg_sched_s0 msg_sched_s0_chk #(
  .WORD_W(WORD_W), .LANES(LANES), .ROT_A(ROT_A), .ROT_B(ROT_B), .SHR_C(SHR_C)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_words (in_words),
  .next_lo  (in_next[WORD_W-1:0]),
  .out_valid(out_valid),
  .out_words(out_words)
);

// File: tb/tb_msg_sched_s0.sv
module tb_msg_sched_s0;
  localparam int NVEC = 6;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [255:0] in_words;
  logic [127:0] in_next;
  logic         out_valid;
  logic [255:0] out_words;

  int n_checks = 0;
  int n_errors = 0;
  bit finished = 1'b0;

  localparam logic [255:0] STIM_W [NVEC] = '{
    256'h0123456789abcdef_fedcba9876543210_0f1e2d3c4b5a6978_8796a5b4c3d2e1f0,
    256'h8000000000000000_0000000000000001_7fffffffffffffff_ffffffffffffff00,
    256'hdeadbeefcafef00d_1122334455667788_99aabbccddeeff00_a5a5a5a55a5a5a5a,
    256'hdeadbeefcafef00d_1122334455667788_99aabbccddeeff00_a5a5a5a55a5a5a5a,
    256'h6a09e667f3bcc908_bb67ae8584caa73b_3c6ef372fe94f82b_a54ff53a5f1d36f1,
    256'hffffffffffffffff_0000000000000000_ffffffffffffffff_0000000000000000
  };
  localparam logic [127:0] STIM_N [NVEC] = '{
    128'h0000000000000000_243f6a8885a308d3,
    128'hffffffffffffffff_8000000000000001,
    128'h0000000000000000_13198a2e03707344,
    128'h5555aaaa5555aaaa_13198a2e03707344,
    128'h1234123412341234_510e527fade682d1,
    128'h0000000000000000_ffffffffffffffff
  };

  msg_sched_s0 dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_words(in_words),
    .in_next(in_next), .out_valid(out_valid), .out_words(out_words)
  );

  always #10 clk = ~clk;

  function automatic logic [63:0] m_s0(input logic [63:0] x);
    return {x[0], x[63:1]} ^ {x[7:0], x[63:8]} ^ {7'b0, x[63:7]};
  endfunction

  function automatic logic [255:0] model(input logic [255:0] w, input logic [127:0] n);
    logic [63:0] ws [5];
    logic [255:0] r;
    for (int k = 0; k < 4; k++) ws[k] = w[k*64 +: 64];
    ws[4] = n[63:0];
    for (int k = 0; k < 4; k++) r[k*64 +: 64] = ws[k] + m_s0(ws[k+1]);
    return r;
  endfunction

  task automatic chk_bit(input logic act, input logic exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: out_valid actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic chk_lanes(input logic [255:0] exp, input string req);
    for (int k = 0; k < 4; k++) begin
      n_checks++;
      if (out_words[k*64 +: 64] !== exp[k*64 +: 64]) begin
        n_errors++;
        $display("FAIL %s lane %0d%s: actual=%h expected=%h", req, k,
                 (k == 3) ? " (R2 top lane)" : "", out_words[k*64 +: 64], exp[k*64 +: 64]);
      end
    end
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
    end
  end

  initial begin
    logic [255:0] exp_prev;
    logic [255:0] res_a;
    rst = 1'b1; in_valid = 1'b0; in_words = '0; in_next = '0;
    repeat (3) @(negedge clk);
    // R6: reset state
    chk_bit(out_valid, 1'b0, "R6 reset state");
    rst = 1'b0;

    // R1 R2 R5: stream the table back to back
    for (int i = 0; i <= NVEC; i++) begin
      @(negedge clk);
      if (i > 0) begin
        chk_bit(out_valid, 1'b1, "R5 streaming");
        chk_lanes(exp_prev, "R1");
        if (i == 3) res_a = out_words;
        // R3: vectors 2 and 3 differ only in the ignored upper half of in_next
        if (i == 4) begin
          n_checks++;
          if (out_words !== res_a) begin
            n_errors++;
            $display("FAIL R3: actual=%h expected=%h", out_words, res_a);
          end
        end
      end
      if (i < NVEC) begin
        in_valid = 1'b1; in_words = STIM_W[i]; in_next = STIM_N[i];
        exp_prev = model(STIM_W[i], STIM_N[i]);
      end else begin
        in_valid = 1'b0; in_words = ~in_words; in_next = ~in_next;
      end
    end

    // R5 R7: idle cycle, valid drops, data held
    @(negedge clk);
    chk_bit(out_valid, 1'b0, "R5 idle");
    chk_lanes(exp_prev, "R7 hold");

    // R8: all zeros
    in_valid = 1'b1; in_words = '0; in_next = '0;
    @(negedge clk);
    in_valid = 1'b0;
    chk_bit(out_valid, 1'b1, "R5 single");
    chk_lanes('0, "R8 zeros");

    // R4: all ones, carries wrap inside each lane
    in_valid = 1'b1; in_words = '1; in_next = '1;
    @(negedge clk);
    in_valid = 1'b0;
    chk_lanes({4{64'h01ff_ffff_ffff_fffe}}, "R4 ones");

    // R6: reset and accept in the same cycle, reset wins
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1; in_words = STIM_W[0]; in_next = STIM_N[0];
    @(negedge clk);
    chk_bit(out_valid, 1'b0, "R6 reset with in_valid");
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    chk_bit(out_valid, 1'b0, "R6 after reset");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule